// File: doc/BRIEF.md
# Isolated Link Health Monitor

The block sits at the receiving end of a serial link that crosses an isolation barrier. It watches two frame streams, one per link direction. The stream in direction 0 is expected to repeat at a fixed period. Every incoming frame carries a payload and an 8-bit CRC. A frame whose CRC matches is accepted and passed on. A frame whose CRC does not match is dropped and has no other effect.

For each direction the block counts CRC failures that occur back to back. When that count reaches its limit, it raises a sticky CRC fault for that direction. A tick-driven watchdog watches the direction-0 stream and raises a sticky loss-of-stream fault when no accepted frame arrives within the allowed number of ticks. The first window after any reset is longer, which leaves room for start-up.

All three faults stay set until a hard-reset request or the asynchronous reset clears them. A fault output reports the faults, gated by a per-flag enable mask.

Top module: `lhm_link_monitor`

## Requirements
- R1: After `rst_ni` is released, `flags_o` is 0, `fault_o` is 0 and `acc_vld_o` is 0.
- R2: A frame on direction d is accepted when `frm_crc_i` for d equals the CRC-8 of its payload. The CRC uses polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, and takes the payload MSB first. In the cycle after an accepted frame, `acc_vld_o[d]` is 1 and the direction's slice of `acc_data_o` holds the payload.
- R3: A frame with a wrong CRC is discarded. `acc_vld_o[d]` stays 0, the payload is not forwarded, and the watchdog is not reloaded.
- R4: In the cycle after the sixth consecutive failed frame on direction d, the CRC flag is set: `flags_o[1]` for direction 0, `flags_o[2]` for direction 1. After five consecutive failures the flag is still clear.
- R5: Any accepted frame on a direction clears that direction's consecutive-failure count. The count saturates at the limit.
- R6: The CRC flags are sticky. Accepted frames do not clear them. Only a hard reset or `rst_ni` does.
- R7: Once start-up has ended, `flags_o[0]` is set in the cycle after the TIMEOUT_TICKS-th `tick_i` pulse that passes with no accepted direction-0 frame.
- R8: Start-up lasts from any reset until the first accepted direction-0 frame. During start-up the watchdog window is STARTUP_TICKS ticks instead of TIMEOUT_TICKS.
- R9: An accepted direction-0 frame restarts the watchdog window.
- R10: `fault_o` is 1 exactly when some bit is set in both `flags_o` and `flt_en_i` (same bit layout).
- R11: While `hard_rst_i` is 1 at a clock edge, the next cycle shows all flags clear, `acc_vld_o` at 0 and the watchdog back in start-up. This holds even if a frame arrives in the same cycle.
- R12: The loss-of-stream flag is sticky. Frames that arrive later do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hard_rst_i | input | 1 | Synchronous hard-reset request; returns all state to defaults |
| tick_i | input | 1 | Watchdog time-base enable, one cycle per tick |
| frm_vld_i | input | 2 | Frame strobe, one bit per direction |
| frm_data_i | input | 2*PAYLOAD_W | Payloads, direction d at bits [d*PAYLOAD_W +: PAYLOAD_W] |
| frm_crc_i | input | 16 | Received CRC bytes, direction d at bits [d*8 +: 8] |
| flt_en_i | input | 3 | Fault enables, same layout as flags_o |
| flags_o | output | 3 | Bit 0 loss of stream, bit 1 CRC fault dir 0, bit 2 CRC fault dir 1 |
| fault_o | output | 1 | OR of the enabled flags |
| acc_vld_o | output | 2 | Accepted-frame strobe per direction |
| acc_data_o | output | 2*PAYLOAD_W | Payload of the last accepted frame per direction |

## Verification
Some properties are checked by the assertions on every cycle:
- a flag never drops without a hard reset;
- a hard reset always leaves the flags and strobes clear;
- a CRC flag only rises right after a frame on its direction;
- the loss-of-stream flag only rises right after a tick;
- an accept strobe always follows a frame strobe.

The exact count behaviour can only be shown by the bench's scenarios, which compare against a cycle model. These cover:
- the sixth-not-fifth threshold;
- the reset of the count by a good frame;
- the longer start-up window and the reload of the watchdog window;
- the payload forwarded and the CRC value that is accepted.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  localparam int unsigned NUM_DIR   = 2;
  localparam int unsigned CRC_W     = 8;
  localparam logic [7:0]  CRC_POLY  = 8'h07;
  localparam int unsigned FLAG_W    = NUM_DIR + 1;
  localparam int unsigned FLAG_COM  = 0;
  localparam int unsigned FLAG_CRC0 = 1;
endpackage

// File: rtl/lhm_crc_chk.sv
module lhm_crc_chk #(
  parameter int unsigned PAYLOAD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hard_rst_i,
  input  logic                 vld_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  input  logic [7:0]           crc_i,
  output logic                 good_o,
  output logic                 bad_o,
  output logic                 acc_vld_o,
  output logic [PAYLOAD_W-1:0] acc_data_o
);
  import lhm_pkg::*;

  logic [7:0] crc_calc;

  // serial LFSR unrolled over the payload, MSB first
  always_comb begin
    logic fb;
    crc_calc = '0;
    for (int i = PAYLOAD_W - 1; i >= 0; i--) begin
      fb       = crc_calc[7] ^ data_i[i];
      crc_calc = {crc_calc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
  end

  assign good_o = vld_i && (crc_calc == crc_i);
  assign bad_o  = vld_i && (crc_calc != crc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_vld_o  <= 1'b0;
      acc_data_o <= '0;
    end else if (hard_rst_i) begin
      acc_vld_o  <= 1'b0;
      acc_data_o <= '0;
    end else begin
      acc_vld_o <= good_o;
      if (good_o) acc_data_o <= data_i;
    end
  end
endmodule

// File: rtl/lhm_fail_cnt.sv
module lhm_fail_cnt #(
  parameter int unsigned FAIL_LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic good_i,
  input  logic bad_i,
  output logic flag_o
);
  localparam int unsigned CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(FAIL_LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(FAIL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (hard_rst_i) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (good_i) begin
      cnt_q <= '0;
    end else if (bad_i && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIM_M1) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lhm_stream_wdog.sv
module lhm_stream_wdog #(
  parameter int unsigned TIMEOUT_TICKS = 100,
  parameter int unsigned STARTUP_TICKS = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic tick_i,
  input  logic good_i,
  output logic flag_o
);
  localparam int unsigned MAX_T = (TIMEOUT_TICKS > STARTUP_TICKS) ? TIMEOUT_TICKS : STARTUP_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] TO_M1 = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] ST_M1 = CNT_W'(STARTUP_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             startup_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = startup_q ? ST_M1 : TO_M1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      startup_q <= 1'b1;
      flag_o    <= 1'b0;
    end else if (hard_rst_i) begin
      cnt_q     <= '0;
      startup_q <= 1'b1;
      flag_o    <= 1'b0;
    end else if (!flag_o) begin
      if (good_i) begin
        cnt_q     <= '0;
        startup_q <= 1'b0;
      end else if (tick_i) begin
        if (cnt_q == last_cnt) flag_o <= 1'b1;
        else                   cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lhm_link_monitor.sv
module lhm_link_monitor #(
  parameter int unsigned PAYLOAD_W     = 16,
  parameter int unsigned FAIL_LIMIT    = 6,
  parameter int unsigned TIMEOUT_TICKS = 100,
  parameter int unsigned STARTUP_TICKS = 400
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hard_rst_i,
  input  logic                   tick_i,
  input  logic [1:0]             frm_vld_i,
  input  logic [2*PAYLOAD_W-1:0] frm_data_i,
  input  logic [15:0]            frm_crc_i,
  input  logic [2:0]             flt_en_i,
  output logic [2:0]             flags_o,
  output logic                   fault_o,
  output logic [1:0]             acc_vld_o,
  output logic [2*PAYLOAD_W-1:0] acc_data_o
);
  import lhm_pkg::*;

  logic [NUM_DIR-1:0] good, bad;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    lhm_crc_chk #(.PAYLOAD_W(PAYLOAD_W)) u_crc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hard_rst_i (hard_rst_i),
      .vld_i      (frm_vld_i[d]),
      .data_i     (frm_data_i[d*PAYLOAD_W +: PAYLOAD_W]),
      .crc_i      (frm_crc_i[d*CRC_W +: CRC_W]),
      .good_o     (good[d]),
      .bad_o      (bad[d]),
      .acc_vld_o  (acc_vld_o[d]),
      .acc_data_o (acc_data_o[d*PAYLOAD_W +: PAYLOAD_W])
    );

    lhm_fail_cnt #(.FAIL_LIMIT(FAIL_LIMIT)) u_fail (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hard_rst_i (hard_rst_i),
      .good_i     (good[d]),
      .bad_i      (bad[d]),
      .flag_o     (flags_o[FLAG_CRC0 + d])
    );
  end

  lhm_stream_wdog #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .STARTUP_TICKS (STARTUP_TICKS)
  ) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_rst_i (hard_rst_i),
    .tick_i     (tick_i),
    .good_i     (good[0]),
    .flag_o     (flags_o[FLAG_COM])
  );

  assign fault_o = |(flags_o & flt_en_i);
endmodule

// File: rtl/lhm_link_monitor_chk.sv
module lhm_link_monitor_chk #(
  parameter int unsigned PAYLOAD_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   hard_rst_i,
  input logic                   tick_i,
  input logic [1:0]             frm_vld_i,
  input logic [2*PAYLOAD_W-1:0] frm_data_i,
  input logic [15:0]            frm_crc_i,
  input logic [2:0]             flt_en_i,
  input logic [2:0]             flags_o,
  input logic                   fault_o,
  input logic [1:0]             acc_vld_o,
  input logic [2*PAYLOAD_W-1:0] acc_data_o
);
  for (genvar i = 1; i < 3; i++) begin : g_crc
    p_crc_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !hard_rst_i) |=> flags_o[i]);
    p_crc_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[i]) |-> $past(frm_vld_i[i-1]));
  end

  p_com_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] && !hard_rst_i) |=> flags_o[0]);

  p_com_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> $past(tick_i));

  p_hard_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (flags_o == 3'b000) && (acc_vld_o == 2'b00));

  for (genvar d = 0; d < 2; d++) begin : g_acc
    p_acc_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_vld_o[d] |-> $past(frm_vld_i[d]));
  end

  p_fault_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (flt_en_i != 3'b000) && (flags_o != 3'b000));
endmodule

bind lhm_link_monitor lhm_link_monitor_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (.*);

// File: tb/lhm_link_monitor_tb.sv
module lhm_link_monitor_tb;
  localparam int W  = 16;
  localparam int TO = 6;
  localparam int ST = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hard_rst = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    fv = '0;
  logic [2*W-1:0] fd = '0;
  logic [15:0]   fc = '0;
  logic [2:0]    en = '0;
  logic [2:0]    flags;
  logic          fault;
  logic [1:0]    avld;
  logic [2*W-1:0] adata;

  int checks = 0;
  int errors = 0;

  // cycle model
  logic [2:0] m_flags;
  int         m_fcnt [2];
  int         m_wcnt;
  logic       m_start;
  logic [1:0] m_avld;
  logic [W-1:0] m_adata [2];

  always #5 clk = ~clk;

  lhm_link_monitor #(.PAYLOAD_W(W), .FAIL_LIMIT(6), .TIMEOUT_TICKS(TO), .STARTUP_TICKS(ST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hard_rst_i(hard_rst), .tick_i(tick),
    .frm_vld_i(fv), .frm_data_i(fd), .frm_crc_i(fc), .flt_en_i(en),
    .flags_o(flags), .fault_o(fault), .acc_vld_o(avld), .acc_data_o(adata));

  function automatic logic [7:0] crc8(input logic [W-1:0] p);
    logic [7:0] c = 8'h00;
    for (int i = W - 1; i >= 0; i--) begin
      logic top = c[7] ^ p[i];
      c = c << 1;
      if (top) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [7:0] bad8(input logic [W-1:0] p);
    logic [7:0] x = 8'($urandom_range(1, 255));
    return crc8(p) ^ x;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_flags = '0; m_fcnt[0] = 0; m_fcnt[1] = 0; m_wcnt = 0; m_start = 1'b1; m_avld = '0;
    m_adata[0] = '0; m_adata[1] = '0;
  endtask

  // drive one cycle, update the model, compare after the edge
  task automatic step(input logic [1:0] v, input logic [W-1:0] p0, input logic [7:0] c0,
                      input logic [W-1:0] p1, input logic [7:0] c1,
                      input logic tk, input logic hr);
    logic [1:0] g;
    @(negedge clk);
    fv = v; fd = {p1, p0}; fc = {c1, c0}; tick = tk; hard_rst = hr;
    @(posedge clk);
    g[0] = v[0] && (crc8(p0) == c0);
    g[1] = v[1] && (crc8(p1) == c1);
    if (hr) begin
      model_reset();
    end else begin
      if (!m_flags[0]) begin
        if (g[0]) begin m_wcnt = 0; m_start = 1'b0; end
        else if (tk) begin
          if (m_wcnt == (m_start ? ST : TO) - 1) m_flags[0] = 1'b1;
          else m_wcnt++;
        end
      end
      for (int d = 0; d < 2; d++) begin
        m_avld[d] = g[d];
        if (g[d]) m_adata[d] = (d == 0) ? p0 : p1;
        if (v[d]) begin
          if (g[d]) m_fcnt[d] = 0;
          else if (m_fcnt[d] < 6) begin
            m_fcnt[d]++;
            if (m_fcnt[d] == 6) m_flags[1+d] = 1'b1;
          end
        end
      end
    end
    #1;
    chk(flags[0] == m_flags[0], "R7 com flag", 64'(flags), 64'(m_flags));
    chk(flags[2:1] == m_flags[2:1], "R4 crc flags", 64'(flags), 64'(m_flags));
    chk(fault == |(m_flags & en), "R10 fault", 64'(fault), 64'(|(m_flags & en)));
    chk(avld == m_avld, "R2 accept strobe", 64'(avld), 64'(m_avld));
    for (int d = 0; d < 2; d++)
      if (m_avld[d])
        chk(adata[d*W +: W] == m_adata[d], "R2 accept data", 64'(adata[d*W +: W]), 64'(m_adata[d]));
  endtask

  task automatic idle(input logic tk);
    step(2'b00, '0, '0, '0, '0, tk, 1'b0);
  endtask

  task automatic good0(input logic [W-1:0] p);
    step(2'b01, p, crc8(p), '0, '0, 1'b0, 1'b0);
  endtask

  task automatic bad_dir(input int d, input logic [W-1:0] p);
    if (d == 0) step(2'b01, p, bad8(p), '0, '0, 1'b0, 1'b0);
    else        step(2'b10, '0, '0, p, bad8(p), 1'b0, 1'b0);
  endtask

  task automatic good_dir(input int d, input logic [W-1:0] p);
    if (d == 0) step(2'b01, p, crc8(p), '0, '0, 1'b0, 1'b0);
    else        step(2'b10, '0, '0, p, crc8(p), 1'b0, 1'b0);
  endtask

  task automatic hreset();
    step(2'b00, '0, '0, '0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] p;
    void'($urandom(32'd7));
    model_reset();
    en = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 3'b000 && fault == 1'b0 && avld == 2'b00, "R1 reset state", 64'({flags, fault, avld}), 64'(0));
    @(negedge clk) rst_n = 1'b1;

    // start-up window is longer
    for (int i = 0; i < ST - 1; i++) idle(1'b1);
    chk(flags[0] == 1'b0, "R8 no com before startup window", 64'(flags[0]), 64'(0));
    idle(1'b1);
    chk(flags[0] == 1'b1, "R8 com at end of startup window", 64'(flags[0]), 64'(1));
    good0(16'h1234);
    chk(flags[0] == 1'b1, "R12 com sticky after good frame", 64'(flags[0]), 64'(1));
    hreset();
    chk(flags == 3'b000, "R11 hard reset clears com", 64'(flags), 64'(0));

    // accept and watchdog reload
    p = 16'hA5C3; good0(p);
    chk(avld[0] == 1'b1 && adata[W-1:0] == p, "R2 accepted payload", 64'(adata[W-1:0]), 64'(p));
    for (int i = 0; i < TO - 1; i++) idle(1'b1);
    good0(16'h00FF);
    for (int i = 0; i < TO - 1; i++) idle(1'b1);
    chk(flags[0] == 1'b0, "R9 reload keeps com clear", 64'(flags[0]), 64'(0));
    idle(1'b1);
    chk(flags[0] == 1'b1, "R7 timeout after reload", 64'(flags[0]), 64'(1));
    hreset();

    // consecutive CRC failures, direction 0
    good0(16'h0001);
    for (int i = 0; i < 5; i++) bad_dir(0, 16'($urandom));
    chk(flags[1] == 1'b0, "R4 five failures no flag", 64'(flags[1]), 64'(0));
    chk(avld[0] == 1'b0, "R3 bad frame not accepted", 64'(avld[0]), 64'(0));
    bad_dir(0, 16'h7777);
    chk(flags[1] == 1'b1, "R4 sixth failure sets flag", 64'(flags[1]), 64'(1));
    good0(16'h4242);
    chk(flags[1] == 1'b1, "R6 crc flag sticky", 64'(flags[1]), 64'(1));
    step(2'b11, 16'h1111, crc8(16'h1111), 16'h2222, crc8(16'h2222), 1'b1, 1'b1);
    chk(flags == 3'b000 && avld == 2'b00, "R11 hard reset dominates frame", 64'({flags, avld}), 64'(0));

    // bad frames do not reload the watchdog
    good0(16'h5555);
    for (int i = 0; i < TO - 1; i++) idle(1'b1);
    bad_dir(0, 16'h3333);
    idle(1'b1);
    chk(flags[0] == 1'b1, "R3 bad frame does not reload", 64'(flags[0]), 64'(1));
    hreset();

    // good frame clears the run, direction 1
    for (int i = 0; i < 5; i++) bad_dir(1, 16'($urandom));
    good_dir(1, 16'hBEEF);
    for (int i = 0; i < 5; i++) bad_dir(1, 16'($urandom));
    chk(flags[2] == 1'b0, "R5 good frame clears count", 64'(flags[2]), 64'(0));
    bad_dir(1, 16'h0F0F);
    chk(flags[2] == 1'b1, "R5 count saturates to flag", 64'(flags[2]), 64'(1));

    // enable gating
    en = 3'b011; idle(1'b0);
    chk(fault == 1'b0, "R10 masked flag", 64'(fault), 64'(0));
    en = 3'b100; idle(1'b0);
    chk(fault == 1'b1, "R10 enabled flag", 64'(fault), 64'(1));
    hreset();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] v;
      logic [W-1:0] p0, p1;
      logic [7:0] c0, c1;
      if (n % 50 == 0) en = 3'($urandom);
      v  = {($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0)};
      p0 = 16'($urandom); p1 = 16'($urandom);
      c0 = ($urandom_range(0, 1) == 0) ? crc8(p0) : bad8(p0);
      c1 = ($urandom_range(0, 1) == 0) ? crc8(p1) : bad8(p1);
      step(v, p0, c0, p1, c1, 1'($urandom), ($urandom_range(0, 299) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule